// File: doc/BRIEF.md
# Auto-Ranging Output Gain Normalizer

This block sits at the tail of a convolution datapath. It reduces a 32-bit signed accumulator word to a 16-bit output sample. First it takes one of four overlapping 20-bit windows out of the word. The windows are spaced four bits apart, so the chosen window sets the coarse scale. The window is then multiplied by a small unsigned gain, and the middle sixteen bits of that product form the output. An overflow flag and two optional clipping behaviours deal with results that do not fit in sixteen bits.

The window can be fixed by a two-bit mode input, or it can follow an automatic tracker. The tracker looks at how many identical sign bits lead each incoming word and keeps the most significant window it has needed so far. It only moves toward more significant windows. A register-update strobe restarts it. After a restart, the tracker stays idle until a set number of line-sync strobes have arrived, which lets the upstream pipeline flush. The tracker's current choice is always visible on a field indicator output, whatever mode is in use.

Top module: `autorange_normalizer`

## Requirements
- R1: With automatic mode off, `manualField` selects the window. Code 0 takes accumulator bits 31:12, code 1 takes bits 27:8, code 2 takes bits 23:4 and code 3 takes bits 19:0.
- R2: The tracker works out a candidate code for each valid word. Let n be the number of leading bits, counted from bit 31, that equal bit 31. The candidate is 0 when n < 5, 1 when 5 <= n < 9, 2 when 9 <= n < 13, and 3 otherwise.
- R3: Once armed, the tracker replaces its code with the candidate only when the candidate is numerically smaller. Between register updates, `fieldInd` never increases.
- R4: Reset or a `regUpdate` pulse sets `fieldInd` to 3 and clears a line counter. The tracker stays inactive until ten `lineSync` pulses have been seen. A valid word in the same cycle as the tenth pulse is still ignored.
- R5: `fieldInd` reports the tracker's code even when `autoEn` is low.
- R6: With `autoEn` high, each valid word uses the tracker code held before that word arrived. A word that moves the tracker therefore takes effect from the next word on.
- R7: The chosen 20-bit window is a signed value. It is multiplied by `gain`, read as unsigned 0..15, to form a 24-bit product. With `clipMode` 0 or 3, `outData` is product bits 19:4.
- R8: `overflow` is high when product bits 23:19 are not all equal. In other words, the product divided by 16 (rounded down) falls outside -32768..32767. This holds in every clip mode.
- R9: With `clipMode` 1, a negative product gives 0x0000. A non-negative product that overflows gives 0x7FFF. Any other product gives bits 19:4.
- R10: With `clipMode` 2, an overflowing product gives 0x7FFF if it is non-negative and 0x8000 if it is negative. Any other product gives bits 19:4.
- R11: `outData` and `overflow` are registered. They reflect the word presented with `inValid` one clock earlier, and `outValid` follows `inValid` with the same single-cycle delay. Without `inValid`, `outData` and `overflow` hold their values. Reset clears all outputs, with `fieldInd` reset to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies `accIn` this cycle |
| accIn | input | 32 | Signed accumulator result |
| lineSync | input | 1 | One-cycle line-sync strobe |
| regUpdate | input | 1 | One-cycle strobe marking a configuration write |
| manualField | input | 2 | Window code used when `autoEn` is low |
| autoEn | input | 1 | Use the tracker's window |
| gain | input | 4 | Unsigned gain multiplier |
| clipMode | input | 2 | 0/3 none, 1 clamp negatives and positive overflow, 2 symmetric saturation |
| outData | output | 16 | Normalized output sample |
| outValid | output | 1 | `outData` updated this cycle |
| fieldInd | output | 2 | Tracker's current window code |
| overflow | output | 1 | Product did not fit 16 bits |

## Verification
The checker relies on two things about the inputs: `lineSync` and `regUpdate` are single-cycle strobes, and the mode inputs stay steady during the cycle that a valid word is accepted. Its hold-off counter mirrors the line counting from reset and from each update. The bench drives every input on the falling clock edge and holds the mode inputs constant around each accepted word. It sends strobes only in cycles with no valid word, except in the ratchet and hold-off cases, which are built deliberately. Expected windows, products, flags and clipped outputs are computed by integer arithmetic from the requirement text.

// File: rtl/gn_pkg.sv
package gn_pkg;

  localparam int FSEL_W = 2;

  localparam logic [1:0] CLIP_NONE    = 2'd0;
  localparam logic [1:0] CLIP_POSONLY = 2'd1;
  localparam logic [1:0] CLIP_SYM     = 2'd2;

  // control -> datapath strobes
  typedef struct packed {
    logic              load;
    logic [FSEL_W-1:0] field;
  } gnStrobe_t;

endpackage

// File: rtl/gn_control.sv
module gn_control
  import gn_pkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int FIELD_W    = 20,
  parameter int STEP       = 4,
  parameter int HOLD_LINES = 10,
  localparam int NF        = (ACC_W - FIELD_W) / STEP + 1,
  localparam int SIGN_W    = 1 + STEP * (NF - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SIGN_W-1:0] signBits,
  input  logic              lineSync,
  input  logic              regUpdate,
  input  logic              autoEn,
  input  logic [FSEL_W-1:0] manualField,
  output gnStrobe_t         strobe,
  output logic [FSEL_W-1:0] fieldInd
);

  localparam int CNT_W = $clog2(HOLD_LINES + 1);
  localparam logic [FSEL_W-1:0] LOWEST = FSEL_W'(NF - 1);

  logic [NF-2:0]     mixed;
  logic [FSEL_W-1:0] cand;
  logic [CNT_W-1:0]  lineCnt;
  logic              armed;
  logic [FSEL_W-1:0] trackField;

  // a group is "mixed" when its leading bits are not all sign copies
  for (genvar k = 0; k < NF - 1; k++) begin : g_grp
    localparam int GW = 1 + STEP * (k + 1);
    logic [GW-1:0] grp;
    assign grp      = signBits[SIGN_W-1 -: GW];
    assign mixed[k] = ~((&grp) | ~(|grp));
  end

  always_comb begin
    cand = LOWEST;
    for (int k = NF - 2; k >= 0; k--) begin
      if (mixed[k]) cand = FSEL_W'(k);
    end
  end

  // hold-off: line syncs counted since the last update
  always_ff @(posedge clk) begin
    if (!rstN || regUpdate) begin
      lineCnt <= '0;
    end else if (lineSync && !armed) begin
      lineCnt <= lineCnt + CNT_W'(1);
    end
  end

  assign armed = (lineCnt == CNT_W'(HOLD_LINES));

  // sticky tracker, ratchets toward lower codes only
  always_ff @(posedge clk) begin
    if (!rstN || regUpdate) begin
      trackField <= LOWEST;
    end else if (armed && inValid && (cand < trackField)) begin
      trackField <= cand;
    end
  end

  assign strobe.load  = inValid;
  assign strobe.field = autoEn ? trackField : manualField;
  assign fieldInd     = trackField;

endmodule

// File: rtl/gn_datapath.sv
module gn_datapath
  import gn_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int FIELD_W = 20,
  parameter int STEP    = 4,
  parameter int GAIN_W  = 4,
  parameter int OUT_W   = 16,
  localparam int NF     = (ACC_W - FIELD_W) / STEP + 1,
  localparam int PROD_W = FIELD_W + GAIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ACC_W-1:0]  accIn,
  input  logic [GAIN_W-1:0] gain,
  input  logic [1:0]        clipMode,
  input  gnStrobe_t         strobe,
  output logic [OUT_W-1:0]  outData,
  output logic              outValid,
  output logic              overflow
);

  localparam int HEAD_W = PROD_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MAXN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [FIELD_W-1:0]       fields [NF];
  logic [FIELD_W-1:0]       selField;
  logic signed [PROD_W-1:0] fExt, gExt, prod, scaled;
  logic [HEAD_W-1:0]        head;
  logic [OUT_W-1:0]         mid, clipped;
  logic                     ovf, neg;

  for (genvar k = 0; k < NF; k++) begin : g_win
    assign fields[k] = accIn[ACC_W-1-STEP*k -: FIELD_W];
  end

  assign selField = fields[strobe.field];
  assign fExt     = {{GAIN_W{selField[FIELD_W-1]}}, selField};
  assign gExt     = {{FIELD_W{1'b0}}, gain};
  assign prod     = fExt * gExt;
  assign scaled   = prod >>> GAIN_W;
  assign mid      = scaled[OUT_W-1:0];
  assign head     = scaled[PROD_W-1:OUT_W-1];
  assign ovf      = ~((&head) | ~(|head));
  assign neg      = scaled[PROD_W-1];

  always_comb begin
    clipped = mid;
    case (clipMode)
      CLIP_POSONLY: begin
        if (neg)      clipped = '0;
        else if (ovf) clipped = MAXP;
      end
      CLIP_SYM: begin
        if (ovf) clipped = neg ? MAXN : MAXP;
      end
      default: clipped = mid;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      overflow <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outData  <= clipped;
        overflow <= ovf;
      end
    end
  end

endmodule

// File: rtl/autorange_normalizer.sv
module autorange_normalizer
  import gn_pkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int FIELD_W    = 20,
  parameter int STEP       = 4,
  parameter int GAIN_W     = 4,
  parameter int OUT_W      = 16,
  parameter int HOLD_LINES = 10,
  localparam int NF        = (ACC_W - FIELD_W) / STEP + 1,
  localparam int SIGN_W    = 1 + STEP * (NF - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ACC_W-1:0]  accIn,
  input  logic              lineSync,
  input  logic              regUpdate,
  input  logic [FSEL_W-1:0] manualField,
  input  logic              autoEn,
  input  logic [GAIN_W-1:0] gain,
  input  logic [1:0]        clipMode,
  output logic [OUT_W-1:0]  outData,
  output logic              outValid,
  output logic [FSEL_W-1:0] fieldInd,
  output logic              overflow
);

  gnStrobe_t strobe;

  gn_control #(
    .ACC_W(ACC_W), .FIELD_W(FIELD_W), .STEP(STEP), .HOLD_LINES(HOLD_LINES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .signBits   (accIn[ACC_W-1 -: SIGN_W]),
    .lineSync   (lineSync),
    .regUpdate  (regUpdate),
    .autoEn     (autoEn),
    .manualField(manualField),
    .strobe     (strobe),
    .fieldInd   (fieldInd)
  );

  gn_datapath #(
    .ACC_W(ACC_W), .FIELD_W(FIELD_W), .STEP(STEP), .GAIN_W(GAIN_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .accIn   (accIn),
    .gain    (gain),
    .clipMode(clipMode),
    .strobe  (strobe),
    .outData (outData),
    .outValid(outValid),
    .overflow(overflow)
  );

endmodule

// File: rtl/gn_checker.sv
module gn_checker #(
  parameter int OUT_W      = 16,
  parameter int HOLD_LINES = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             lineSync,
  input logic             regUpdate,
  input logic [1:0]       clipMode,
  input logic [OUT_W-1:0] outData,
  input logic             outValid,
  input logic [1:0]       fieldInd,
  input logic             overflow
);

  localparam int CNT_W = $clog2(HOLD_LINES + 1);
  localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MAXN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [CNT_W-1:0] linesSince;

  always_ff @(posedge clk) begin
    if (!rstN || regUpdate) linesSince <= '0;
    else if (lineSync && linesSince != CNT_W'(HOLD_LINES)) linesSince <= linesSince + CNT_W'(1);
  end

  assert_ratchet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !regUpdate |=> fieldInd <= $past(fieldInd));

  assert_update_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    regUpdate |=> fieldInd == 2'd3);

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linesSince < CNT_W'(HOLD_LINES)) |-> fieldInd == 2'd3);

  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outData) && $stable(overflow)));

  assert_posonly_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && clipMode == 2'd1) |=> !outData[OUT_W-1]);

  assert_sym_sat_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && clipMode == 2'd2) |=> (!overflow || outData == MAXP || outData == MAXN));

endmodule

bind autorange_normalizer gn_checker #(.OUT_W(OUT_W), .HOLD_LINES(HOLD_LINES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .lineSync (lineSync),
  .regUpdate(regUpdate),
  .clipMode (clipMode),
  .outData  (outData),
  .outValid (outValid),
  .fieldInd (fieldInd),
  .overflow (overflow)
);

// File: tb/autorange_normalizer_tb.sv
module autorange_normalizer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] accIn = '0;
  logic        lineSync = 1'b0;
  logic        regUpdate = 1'b0;
  logic [1:0]  manualField = '0;
  logic        autoEn = 1'b0;
  logic [3:0]  gain = '0;
  logic [1:0]  clipMode = '0;
  logic [15:0] outData;
  logic        outValid;
  logic [1:0]  fieldInd;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  autorange_normalizer u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accIn(accIn),
    .lineSync(lineSync), .regUpdate(regUpdate), .manualField(manualField),
    .autoEn(autoEn), .gain(gain), .clipMode(clipMode),
    .outData(outData), .outValid(outValid), .fieldInd(fieldInd), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // leading-sign count rule
  function automatic logic [1:0] expField(input logic [31:0] a);
    int n = 1;
    bit run = 1;
    for (int i = 30; i >= 0; i--) begin
      if (run && a[i] == a[31]) n++;
      else run = 0;
    end
    if (n < 5) return 2'd0;
    if (n < 9) return 2'd1;
    if (n < 13) return 2'd2;
    return 2'd3;
  endfunction

  // {overflow, outData}
  function automatic logic [16:0] expOut(input logic [31:0] a, input int code,
                                         input int g, input int cm);
    logic signed [19:0] f;
    int p, q;
    logic ov;
    logic [15:0] r;
    f  = a[31-4*code -: 20];
    p  = int'(f) * g;
    q  = p >>> 4;
    ov = (q > 32767) || (q < -32768);
    r  = q[15:0];
    if (cm == 1) begin
      if (p < 0) r = 16'h0000;
      else if (ov) r = 16'h7FFF;
    end else if (cm == 2) begin
      if (ov) r = (p < 0) ? 16'h8000 : 16'h7FFF;
    end
    return {ov, r};
  endfunction

  task automatic sample(input logic [31:0] a);
    @(negedge clk);
    accIn = a; inValid = 1'b1; lineSync = 1'b0; regUpdate = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; lineSync = 1'b0; regUpdate = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk);
    inValid = 1'b0; lineSync = 1'b1;
    @(negedge clk);
    lineSync = 1'b0;
  endtask

  task automatic pulseUpdate();
    @(negedge clk);
    inValid = 1'b0; regUpdate = 1'b1;
    @(negedge clk);
    regUpdate = 1'b0;
  endtask

  task automatic rearm();
    pulseUpdate();
    for (int i = 0; i < 10; i++) pulseSync();
  endtask

  logic [31:0] pats [12] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                             32'h8000_0000, 32'h0000_FFF0, 32'h0001_2345, 32'hFFFE_DCBA,
                             32'h0008_0000, 32'hFFF8_0000, 32'h1234_5678, 32'h8000_0001};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic [16:0] e;
    logic [31:0] v;
    logic [15:0] held;

    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset outValid", {31'd0, outValid}, 32'd0);
    chk("R11 reset outData", {16'd0, outData}, 32'd0);
    chk("R11 reset overflow", {31'd0, overflow}, 32'd0);
    chk("R4 reset fieldInd", {30'd0, fieldInd}, 32'd3);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R7 R8 R9 R10 R12: manual window sweep
    autoEn = 1'b0;
    for (int code = 0; code < 4; code++) begin
      for (int cm = 0; cm < 4; cm++) begin
        for (int g = 0; g < 16; g++) begin
          for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            manualField = 2'(code); clipMode = 2'(cm); gain = 4'(g);
            sample(pats[i]);
            e = expOut(pats[i], code, g, cm);
            chk("R1/R7/R9/R10 outData", {16'd0, outData}, {16'd0, e[15:0]});
            chk("R8 overflow", {31'd0, overflow}, {31'd0, e[16]});
            chk("R11 outValid", {31'd0, outValid}, 32'd1);
          end
        end
      end
    end
    // no line syncs yet: tracker still inactive
    chk("R4 no syncs fieldInd", {30'd0, fieldInd}, 32'd3);

    // R11 hold without valid
    idle();
    @(posedge clk); #1;
    held = outData;
    @(negedge clk);
    accIn = 32'h4000_0000; gain = 4'd15;
    @(posedge clk); #1;
    chk("R11 idle outValid", {31'd0, outValid}, 32'd0);
    chk("R11 idle hold", {16'd0, outData}, {16'd0, held});

    // R4 hold-off boundary
    pulseUpdate();
    for (int i = 0; i < 9; i++) pulseSync();
    sample(32'h8000_0000);
    chk("R4 nine syncs fieldInd", {30'd0, fieldInd}, 32'd3);
    @(negedge clk);
    inValid = 1'b1; lineSync = 1'b1; accIn = 32'h8000_0000;
    @(posedge clk); #1;
    chk("R4 tenth sync same cycle", {30'd0, fieldInd}, 32'd3);
    sample(32'h8000_0000);
    chk("R4 armed after ten", {30'd0, fieldInd}, 32'd0);
    pulseUpdate();
    @(posedge clk); #1;
    chk("R4 update clears", {30'd0, fieldInd}, 32'd3);

    // R2 R5: candidate sweep with autoEn low
    autoEn = 1'b0;
    for (int k = 0; k < 32; k++) begin
      for (int t = 0; t < 3; t++) begin
        v = (t == 0) ? (32'd1 << k) : (t == 1) ? ~(32'd1 << k) : -(32'd1 << k);
        rearm();
        sample(v);
        chk("R2/R5 candidate", {30'd0, fieldInd}, {30'd0, expField(v)});
      end
    end

    // R3 ratchet
    rearm();
    sample(32'h0010_0000);
    chk("R3 to 2", {30'd0, fieldInd}, 32'd2);
    sample(32'h0000_0005);
    chk("R3 no move down", {30'd0, fieldInd}, 32'd2);
    sample(32'h0080_0000);
    chk("R3 to 1", {30'd0, fieldInd}, 32'd1);
    sample(32'hFFFF_FFF0);
    chk("R3 stays 1", {30'd0, fieldInd}, 32'd1);

    // R6 auto mode uses prior tracker code
    @(negedge clk);
    autoEn = 1'b1; manualField = 2'd3; gain = 4'd3; clipMode = 2'd0;
    sample(32'h0012_3456);
    e = expOut(32'h0012_3456, 1, 3, 0);
    chk("R6 auto uses field 1", {16'd0, outData}, {16'd0, e[15:0]});
    sample(32'h4000_0000);
    e = expOut(32'h4000_0000, 1, 3, 0);
    chk("R6 moving word uses old field", {16'd0, outData}, {16'd0, e[15:0]});
    chk("R6 tracker moved", {30'd0, fieldInd}, 32'd0);
    sample(32'h0012_3456);
    e = expOut(32'h0012_3456, 0, 3, 0);
    chk("R6 next word uses field 0", {16'd0, outData}, {16'd0, e[15:0]});
    idle();

    done = 1;
    summary();
  end

endmodule